// File: doc/BRIEF.md
# FIFO Ticket Lock Unit

This block is a shared hardware lock that admits up to `NUM_REQ` requesters strictly in the order in which they asked. It keeps two wrap-around counters. The issue counter records how many tickets have been handed out. The serve counter records how many releases have been accepted. A requester pulses its acquire strobe and gets back a ticket, which is the issue count before its own increment. It then watches the serve counter and owns the lock while that counter equals its ticket. The owner pulses the release strobe to pass the lock to the next ticket.

If several requesters pulse in the same cycle, the unit orders them by ascending lane index. Each one gets a distinct ticket in the cycle after its strobe. A release while no ticket is outstanding changes nothing except a sticky error flag, which only reset clears. Counters are `$clog2(NUM_REQ)+1` bits wide. Because ownership is an equality test, it stays correct when the counters wrap. The protocol assumes each requester holds at most one outstanding ticket.

Top module: `ticket_lock_unit`

## Requirements
- R1: At each clock edge the issue counter advances by the number of acquire strobes sampled at that edge, modulo 2^CNT_W.
- R2: An acquire strobe on lane i sampled at an edge raises `acq_valid[i]` for exactly the following cycle. In that cycle, bits `[i*CNT_W +: CNT_W]` of `acq_ticket` carry the issue count from before that edge.
- R3: Strobes sampled at the same edge get consecutive tickets in ascending lane order: lane 0 first, then the higher lanes.
- R4: A release sampled while the serve counter differs from the issue counter advances `serving` by exactly one at that edge. Successive owners therefore follow ticket order.
- R5: After reset, `serving` is 0, `rel_err` is 0, `acq_valid` is all zero and the first ticket handed out is 0.
- R6: Tickets and `serving` wrap from 2^CNT_W-1 to 0. The holder of a wrapped ticket still sees `serving` equal to its ticket.
- R7: A release sampled while the serve and issue counters are equal leaves `serving` unchanged and sets `rel_err`. `rel_err` then stays 1 until reset.
- R8: A release and acquires sampled at the same edge are both judged against the counter values from before that edge. An acquire does not make a same-cycle release valid, and the acquire's ticket is unaffected by the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | NUM_REQ | One-cycle acquire strobe per requester lane |
| acq_valid | output | NUM_REQ | Ticket-returned pulse per lane, one cycle after the strobe |
| acq_ticket | output | NUM_REQ*CNT_W | Per-lane ticket, lane i at bits [i*CNT_W +: CNT_W] |
| rel_strobe | input | 1 | Release pulse from the current owner |
| serving | output | CNT_W | Serve counter; the holder's ticket equals this value |
| rel_err | output | 1 | Sticky flag for a release with no outstanding ticket |

## Verification
An acquire and a release can be sampled at the same edge. This matters most when the lock is idle, because the new ticket would otherwise seem to justify the release. The bench drives both strobes in one cycle twice: once with the lock idle, where the release must be refused and the error flag set, and once with the lock held, where the release must advance `serving` while the acquire takes the pre-edge issue count. A reference model built from the requirements predicts every ticket, every `serving` value and the error flag after each edge.

// File: rtl/tl_pkg.sv
package tl_pkg;

    // Outcome of a release strobe for one cycle
    typedef enum logic [1:0] {
        REL_IDLE   = 2'd0,
        REL_STEP   = 2'd1,
        REL_REFUSE = 2'd2
    } rel_kind_e;

    // Counter width for a given number of requesters: one extra bit so that
    // NUM_REQ outstanding tickets never alias the empty state
    function automatic int tl_cnt_w(input int n);
        return $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/tl_ticket_alloc.sv
module tl_ticket_alloc #(
    parameter int N = 4,
    parameter int W = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   req,
    output logic [W-1:0]   next_q,
    output logic [N*W-1:0] ticket_flat,
    output logic [N-1:0]   valid_q
);
    // Running base: lane i receives the issue count plus the strobes of lanes below it
    logic [W-1:0] base [N+1];

    assign base[0] = next_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_lane
            logic [W-1:0] tk_q;

            assign base[i+1] = base[i] + W'(req[i]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    tk_q <= '0;
                end else if (req[i]) begin
                    tk_q <= base[i];
                end
            end

            assign ticket_flat[i*W +: W] = tk_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q  <= '0;
            valid_q <= '0;
        end else begin
            next_q  <= base[N];
            valid_q <= req;
        end
    end

endmodule

// File: rtl/tl_serve_ctr.sv
module tl_serve_ctr
    import tl_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rel,
    input  logic [W-1:0] next_q,
    output logic [W-1:0] serve_q,
    output logic         err_q,
    output rel_kind_e    kind
);
    // Decision uses the counters as they stand before this edge
    always_comb begin
        if (!rel) begin
            kind = REL_IDLE;
        end else if (serve_q == next_q) begin
            kind = REL_REFUSE;
        end else begin
            kind = REL_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            serve_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (kind)
                REL_STEP:   serve_q <= serve_q + W'(1);
                REL_REFUSE: err_q   <= 1'b1;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
    import tl_pkg::*;
#(
    parameter int NUM_REQ = 4,
    localparam int CNT_W  = tl_cnt_w(NUM_REQ)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_REQ-1:0]       acq_req,
    output logic [NUM_REQ-1:0]       acq_valid,
    output logic [NUM_REQ*CNT_W-1:0] acq_ticket,
    input  logic                     rel_strobe,
    output logic [CNT_W-1:0]         serving,
    output logic                     rel_err
);
    logic [CNT_W-1:0] next_q;
    rel_kind_e        rel_kind;

    tl_ticket_alloc #(.N(NUM_REQ), .W(CNT_W)) u_alloc (
        .clk         (clk),
        .rst         (rst),
        .req         (acq_req),
        .next_q      (next_q),
        .ticket_flat (acq_ticket),
        .valid_q     (acq_valid)
    );

    tl_serve_ctr #(.W(CNT_W)) u_serve (
        .clk     (clk),
        .rst     (rst),
        .rel     (rel_strobe),
        .next_q  (next_q),
        .serve_q (serving),
        .err_q   (rel_err),
        .kind    (rel_kind)
    );

endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
    parameter int N = 4,
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] acq_req,
    input logic [N-1:0] acq_valid,
    input logic         rel_strobe,
    input logic [W-1:0] serving,
    input logic         rel_err,
    input logic [W-1:0] next_q
);
    AST_ISSUE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> W'(next_q - $past(next_q)) == W'($countones($past(acq_req)))); // R1

    AST_VALID_ECHO: assert property (@(posedge clk) disable iff (rst)
        (acq_req != '0) |=> acq_valid == $past(acq_req)); // R2

    AST_SERVE_STEP: assert property (@(posedge clk) disable iff (rst)
        (rel_strobe && serving != next_q) |=> serving == W'($past(serving) + W'(1))); // R4

    AST_REL_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (rel_strobe && serving == next_q) |=> ($stable(serving) && rel_err)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        rel_err |=> rel_err); // R7

    AST_SERVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rel_strobe |=> $stable(serving)); // R4

endmodule

bind ticket_lock_unit tl_checker #(.N(NUM_REQ), .W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acq_req    (acq_req),
    .acq_valid  (acq_valid),
    .rel_strobe (rel_strobe),
    .serving    (serving),
    .rel_err    (rel_err),
    .next_q     (next_q)
);

// File: tb/tb_ticket_lock_unit.sv
module tb_ticket_lock_unit;
    localparam int P = 4;
    localparam int W = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [P-1:0]   acq_req = '0;
    logic [P-1:0]   acq_valid;
    logic [P*W-1:0] acq_ticket;
    logic           rel_strobe = 1'b0;
    logic [W-1:0]   serving;
    logic           rel_err;

    int total = 0;
    int bad   = 0;

    logic [W-1:0] m_next, m_serv;
    logic         m_err;
    logic [W-1:0] last_tk [P];

    always #10 clk = ~clk;

    ticket_lock_unit #(.NUM_REQ(P)) dut (
        .clk(clk), .rst(rst), .acq_req(acq_req), .acq_valid(acq_valid),
        .acq_ticket(acq_ticket), .rel_strobe(rel_strobe),
        .serving(serving), .rel_err(rel_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acq_req = '0; rel_strobe = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        m_next = '0; m_serv = '0; m_err = 1'b0;
    endtask

    // One cycle of stimulus, model update and port checks
    task automatic step(input logic [P-1:0] req, input logic rel, input string tag);
        logic [W-1:0] exp_tk [P];
        logic [W-1:0] ofs;
        logic         refuse;
        ofs = '0;
        for (int i = 0; i < P; i++) begin
            exp_tk[i] = W'(m_next + ofs);
            if (req[i]) ofs = W'(ofs + 1);
        end
        refuse = rel && (m_serv == m_next);
        @(negedge clk);
        acq_req = req; rel_strobe = rel;
        @(posedge clk); #1;
        acq_req = '0; rel_strobe = 1'b0;
        m_next = W'(m_next + ofs);
        if (rel && !refuse) m_serv = W'(m_serv + 1);
        if (refuse) m_err = 1'b1;
        chk({tag, " valid"}, int'(acq_valid), int'(req));
        for (int i = 0; i < P; i++) begin
            if (req[i]) begin
                last_tk[i] = acq_ticket[i*W +: W];
                chk({tag, " ticket"}, int'(acq_ticket[i*W +: W]), int'(exp_tk[i]));
            end
        end
        chk({tag, " serving"}, int'(serving), int'(m_serv));
        chk({tag, " err"}, int'(rel_err), int'(m_err));
    endtask

    task automatic t_reset();
        do_reset();
        chk("R5 serving", int'(serving), 0);
        chk("R5 err", int'(rel_err), 0);
        chk("R5 valid", int'(acq_valid), 0);
        step(4'b0100, 1'b0, "R5 R2 first ticket");
        chk("R5 first ticket zero", int'(last_tk[2]), 0);
        @(posedge clk); #1;
        chk("R2 valid one cycle", int'(acq_valid), 0);
    endtask

    task automatic t_burst();
        do_reset();
        step(4'b1111, 1'b0, "R3 R1 all lanes");
        chk("R3 lane0 lowest", int'(last_tk[0]), 0);
        chk("R3 lane3 highest", int'(last_tk[3]), 3);
        step(4'b1010, 1'b0, "R3 after full");
    endtask

    task automatic t_fifo();
        do_reset();
        step(4'b0001, 1'b0, "R4 a");
        step(4'b1000, 1'b0, "R4 b");
        step(4'b0110, 1'b0, "R4 c");
        for (int k = 0; k < 4; k++) step(4'b0000, 1'b1, "R4 release order");
        chk("R4 serving reached issue", int'(serving), 4);
    endtask

    task automatic t_err();
        do_reset();
        step(4'b0000, 1'b1, "R7 idle release");
        chk("R7 serving unchanged", int'(serving), 0);
        step(4'b0001, 1'b0, "R7 after err");
        step(4'b0000, 1'b1, "R7 legal release");
        chk("R7 err sticky", int'(rel_err), 1);
    endtask

    task automatic t_same();
        do_reset();
        step(4'b0010, 1'b1, "R8 idle acq+rel");
        chk("R8 refused", int'(serving), 0);
        step(4'b0100, 1'b1, "R8 held acq+rel");
        chk("R8 ticket pre-edge", int'(last_tk[2]), 1);
        chk("R8 advanced", int'(serving), 1);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int r = 0; r < 11; r++) begin
            step(4'b0001, 1'b0, "R6 wrap acq");
            chk("R6 holder sees serving", int'(serving), int'(last_tk[0]));
            step(4'b0000, 1'b1, "R6 wrap rel");
        end
        chk("R6 wrapped serving", int'(serving), 11 % 8);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_burst();
                t_fifo();
                t_wrap();
                t_same();
                t_err();
            end
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule